// File: doc/BRIEF.md
# GPIO Port with Per-Pin Trigger Detection

This block is a 32-pin general-purpose I/O port. It holds an output data word and a direction word that drive the pad side, and returns the synchronized pin levels on read. Each pin also carries a 4-bit trigger code. The code decides whether the pin raises nothing, a DMA request on an edge, or an interrupt on an edge or a level. Detected events latch into a sticky per-pin flag. All flags together form one status word.

Software reaches the port over a single-cycle register interface with two address spaces: a data space and a trigger space. A flag is cleared by writing 1 to its bit in the status word, or by setting the clear bit in the pin's own trigger register. One interrupt line serves the whole port and is the OR of the pending flags of interrupt-mode pins. A separate DMA request line is the OR of the pending flags of DMA-mode pins.

Top module: `gpio_trig_port`

## Requirements
- R1: After reset the output word, the direction word, every trigger code and every flag read as zero, and `irq` and `dma_req` are low.
- R2: A write in the data space (`reg_space`=0) at offset 0x00 loads the output word. It drives `pin_out` from the next cycle and reads back unchanged.
- R3: A write in the data space at offset 0x14 loads the direction word, where 1 means output. It drives `pin_oe` from the next cycle and reads back unchanged.
- R4: A read in the data space at offset 0x10 returns the pin levels after a two-flop synchronizer. A change at `pin_in` shows up after the second rising clock edge.
- R5: In the trigger space (`reg_space`=1), pin n has a register at offset 4·n. Its trigger code is bits 19:16, and it reads back the code in bits 19:16 and the pin's flag in bit 24.
- R6: Code 0x9 flags a rising edge, 0xA flags a falling edge and 0xB flags either edge. The flag appears after the third rising clock edge that follows the pin change.
- R7: Code 0x8 flags while the pin is low and 0xC flags while it is high. If the level is still present after a clear, the flag sets again one cycle later.
- R8: Codes 0x1 (rising), 0x2 (falling) and 0x3 (either edge) set the flag and raise `dma_req`, and do not raise `irq`.
- R9: The status word in the trigger space at offset 0xA0 holds one flag per pin, with bit n for pin n. Writing 1 clears a flag, and writing 0 leaves it unchanged. A clear wins over a detection in the same cycle.
- R10: A trigger-register write with bit 24 set clears that pin's flag. The same write also loads the code from bits 19:16.
- R11: `irq` is high exactly when a flag of a pin with an interrupt code (0x8 to 0xC) is set.
- R12: Code 0x0 and all unlisted codes (0x4 to 0x7, 0xD to 0xF) never set a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_in | input | 32 | Pin levels from the pads, asynchronous |
| pin_out | output | 32 | Output data word to the pads |
| pin_oe | output | 32 | Output enable per pin (1 = drive) |
| reg_space | input | 1 | 0 selects the data space, 1 selects the trigger space |
| reg_addr | input | 8 | Byte offset within the selected space |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Combined interrupt request |
| dma_req | output | 1 | Combined DMA request |

## Verification
The in-line properties assume that the reset input is asserted from time zero, that the register controls (`reg_wr`, `reg_space`, `reg_addr`) are never unknown once reset is released, and that a write strobe lasts exactly one cycle. The bench drives all inputs at the falling clock edge from tasks. It holds every control at a defined value from time zero and pulses `reg_wr` for a single cycle per access. Pin changes are also applied at the falling edge, so the edge at which the synchronizer captures each change is fixed.

// File: rtl/gpio_trig_pkg.sv
package gpio_trig_pkg;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned CODE_LSB = 16;
  localparam int unsigned CLR_BIT  = 24;

  localparam logic [7:0] OFS_DOUT = 8'h00;
  localparam logic [7:0] OFS_DIN  = 8'h10;
  localparam logic [7:0] OFS_DIR  = 8'h14;
  localparam logic [7:0] OFS_STAT = 8'hA0;

  typedef enum logic [CODE_W-1:0] {
    TRG_OFF      = 4'h0,
    TRG_DMA_RISE = 4'h1,
    TRG_DMA_FALL = 4'h2,
    TRG_DMA_ANY  = 4'h3,
    TRG_IRQ_LO   = 4'h8,
    TRG_IRQ_RISE = 4'h9,
    TRG_IRQ_FALL = 4'hA,
    TRG_IRQ_ANY  = 4'hB,
    TRG_IRQ_HI   = 4'hC
  } trig_e;

  function automatic logic code_is_dma(input logic [CODE_W-1:0] c);
    return (c == TRG_DMA_RISE) || (c == TRG_DMA_FALL) || (c == TRG_DMA_ANY);
  endfunction

  function automatic logic code_is_irq(input logic [CODE_W-1:0] c);
    return (c >= TRG_IRQ_LO) && (c <= TRG_IRQ_HI);
  endfunction

  function automatic logic code_rise(input logic [CODE_W-1:0] c);
    return (c == TRG_DMA_RISE) || (c == TRG_DMA_ANY) ||
           (c == TRG_IRQ_RISE) || (c == TRG_IRQ_ANY);
  endfunction

  function automatic logic code_fall(input logic [CODE_W-1:0] c);
    return (c == TRG_DMA_FALL) || (c == TRG_DMA_ANY) ||
           (c == TRG_IRQ_FALL) || (c == TRG_IRQ_ANY);
  endfunction
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_ns = stage_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
    end
  end

  assign sync_out = sync_q;
endmodule

// File: rtl/gpio_pin_trig.sv
module gpio_pin_trig
  import gpio_trig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl_in,
  input  logic              code_we,
  input  logic [CODE_W-1:0] code_wdata,
  input  logic              flag_clr,
  output logic [CODE_W-1:0] code_q,
  output logic              flag_q,
  output logic              irq_pend,
  output logic              dma_pend
);
  logic              prev_q;
  logic [CODE_W-1:0] code_d;
  logic              flag_d;
  logic              hit;
  logic              rise, fall;

  always_comb begin
    rise   = lvl_in & ~prev_q;
    fall   = ~lvl_in & prev_q;
    hit    = (code_rise(code_q) & rise) |
             (code_fall(code_q) & fall) |
             ((code_q == TRG_IRQ_HI) & lvl_in) |
             ((code_q == TRG_IRQ_LO) & ~lvl_in);
    code_d = code_we ? code_wdata : code_q;
    if (flag_clr) flag_d = 1'b0;
    else          flag_d = flag_q | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      code_q <= '0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= lvl_in;
      code_q <= code_d;
      flag_q <= flag_d;
    end
  end

  assign irq_pend = flag_q & code_is_irq(code_q);
  assign dma_pend = flag_q & code_is_dma(code_q);

  // R9: a clear request always leaves the flag low on the next cycle
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !flag_q);

  // R12: an inactive code never raises a flag
  a_r12_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    (!code_is_irq(code_q) && !code_is_dma(code_q) && !flag_q) |=> !flag_q);

  // R7: a held active-high level sets the flag unless cleared
  a_r7_level_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == TRG_IRQ_HI && lvl_in && !flag_clr) |=> flag_q);

  // R7: a held active-low level sets the flag unless cleared
  a_r7_level_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == TRG_IRQ_LO && !lvl_in && !flag_clr) |=> flag_q);
endmodule

// File: rtl/gpio_trig_port.sv
module gpio_trig_port
  import gpio_trig_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  input  logic             reg_space,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_wr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             irq,
  output logic             dma_req
);
  localparam int unsigned IDX_W   = $clog2(NPINS);
  localparam int unsigned CFG_TOP = NPINS * 4;

  logic             rst_ns;
  logic [NPINS-1:0] lvl_sync;
  logic [NPINS-1:0] dout_q, dout_d, dir_q, dir_d;
  logic [NPINS-1:0] flags, irq_vec, dma_vec, clr_vec;
  logic [CODE_W-1:0] code_arr [NPINS];
  logic             dat_wr, cfg_hit, cfg_wr, stat_hit, stat_wr;
  logic [IDX_W-1:0] pin_idx;

  gpio_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  gpio_in_sync #(.WIDTH(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_ns), .async_in(pin_in), .sync_out(lvl_sync)
  );

  always_comb begin
    dat_wr   = reg_wr & ~reg_space;
    cfg_hit  = reg_space && (reg_addr[1:0] == 2'b00) && (int'(reg_addr) < CFG_TOP);
    cfg_wr   = reg_wr & cfg_hit;
    stat_hit = reg_space && (reg_addr == OFS_STAT);
    stat_wr  = reg_wr & stat_hit;
    pin_idx  = reg_addr[IDX_W+1:2];
    dout_d   = (dat_wr && reg_addr == OFS_DOUT) ? reg_wdata[NPINS-1:0] : dout_q;
    dir_d    = (dat_wr && reg_addr == OFS_DIR)  ? reg_wdata[NPINS-1:0] : dir_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      dout_q <= '0;
      dir_q  <= '0;
    end else begin
      dout_q <= dout_d;
      dir_q  <= dir_d;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic sel;
    assign sel        = cfg_wr && (pin_idx == IDX_W'(i));
    assign clr_vec[i] = (stat_wr & reg_wdata[i]) | (sel & reg_wdata[CLR_BIT]);

    gpio_pin_trig u_pin (
      .clk       (clk),
      .rst_n     (rst_ns),
      .lvl_in    (lvl_sync[i]),
      .code_we   (sel),
      .code_wdata(reg_wdata[CODE_LSB +: CODE_W]),
      .flag_clr  (clr_vec[i]),
      .code_q    (code_arr[i]),
      .flag_q    (flags[i]),
      .irq_pend  (irq_vec[i]),
      .dma_pend  (dma_vec[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (!reg_space) begin
      case (reg_addr)
        OFS_DOUT: reg_rdata = DW'(dout_q);
        OFS_DIN:  reg_rdata = DW'(lvl_sync);
        OFS_DIR:  reg_rdata = DW'(dir_q);
        default:  reg_rdata = '0;
      endcase
    end else if (cfg_hit) begin
      reg_rdata[CODE_LSB +: CODE_W] = code_arr[pin_idx];
      reg_rdata[CLR_BIT]            = flags[pin_idx];
    end else if (stat_hit) begin
      reg_rdata = DW'(flags);
    end
  end

  assign pin_out = dout_q;
  assign pin_oe  = dir_q;
  assign irq     = |irq_vec;
  assign dma_req = |dma_vec;

  // R3: a direction write is visible on the enables next cycle
  a_r3_dir_load: assert property (@(posedge clk) disable iff (!rst_ns)
    (reg_wr && !reg_space && reg_addr == OFS_DIR) |=> pin_oe == $past(reg_wdata[NPINS-1:0]));

  // R2: an output-data write is visible on the pins next cycle
  a_r2_dout_load: assert property (@(posedge clk) disable iff (!rst_ns)
    (reg_wr && !reg_space && reg_addr == OFS_DOUT) |=> pin_out == $past(reg_wdata[NPINS-1:0]));

  // R11: with no flag pending both request lines stay low
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_ns)
    (flags == '0) |-> (!irq && !dma_req));

  // R8: the DMA line only rises while some flag is set
  a_r8_dma_src: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(dma_req) |-> (flags != '0));
endmodule

// File: tb/test_gpio_trig_port.sv
module test_gpio_trig_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pin_in;
  logic [31:0] pin_out, pin_oe;
  logic        reg_space;
  logic [7:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq, dma_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  gpio_trig_port i_gpio_trig_port (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .reg_space(reg_space), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .dma_req(dma_req)
  );

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sp, input logic [7:0] a, input logic [31:0] d);
    reg_space = sp; reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic sp, input logic [7:0] a, output logic [31:0] d);
    reg_space = sp; reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] cfgw(input logic [3:0] code, input logic clr);
    return (32'(clr) << 24) | (32'(code) << 16);
  endfunction

  task automatic clear_all();
    wr(1'b1, 8'hA0, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(1'b0, 8'h00, v); chk("R1 dout", v, 32'h0);
    rd(1'b0, 8'h14, v); chk("R1 dir", v, 32'h0);
    rd(1'b1, 8'hA0, v); chk("R1 status", v, 32'h0);
    rd(1'b1, 8'h7C, v); chk("R1 cfg31", v, 32'h0);
    chk("R1 irq/dma", {30'h0, irq, dma_req}, 32'h0);
  endtask

  task automatic t_data();
    logic [31:0] v;
    wr(1'b0, 8'h00, 32'hA5A5_0F0F);
    chk("R2 pin_out", pin_out, 32'hA5A5_0F0F);
    rd(1'b0, 8'h00, v); chk("R2 readback", v, 32'hA5A5_0F0F);
    wr(1'b0, 8'h14, 32'hFFFF_0000);
    chk("R3 pin_oe", pin_oe, 32'hFFFF_0000);
    rd(1'b0, 8'h14, v); chk("R3 readback", v, 32'hFFFF_0000);
    chk("R2 pin_out kept", pin_out, 32'hA5A5_0F0F);
  endtask

  task automatic t_input();
    logic [31:0] v;
    pin_in = 32'h1234_5678;
    tick();
    rd(1'b0, 8'h10, v); chk("R4 one edge", v, 32'h0);
    tick();
    rd(1'b0, 8'h10, v); chk("R4 two edges", v, 32'h1234_5678);
    pin_in = '0;
    tick(3);
    rd(1'b0, 8'h10, v); chk("R4 back low", v, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(1'b1, 8'h0C, cfgw(4'h9, 1'b0));
    wr(1'b1, 8'h10, cfgw(4'hA, 1'b0));
    wr(1'b1, 8'h18, cfgw(4'hB, 1'b0));
    rd(1'b1, 8'h0C, v); chk("R5 cfg3", v, 32'h0009_0000);
    pin_in[3] = 1'b1; pin_in[4] = 1'b1; pin_in[6] = 1'b1;
    tick(2);
    rd(1'b1, 8'hA0, v); chk("R6 not yet", v, 32'h0);
    tick();
    rd(1'b1, 8'hA0, v); chk("R6 rise", v, 32'h0000_0048);
    rd(1'b1, 8'h0C, v); chk("R5 flag bit", v, 32'h0109_0000);
    chk("R11 irq edge", {31'h0, irq}, 32'h1);
    clear_all();
    pin_in[3] = 1'b0; pin_in[4] = 1'b0; pin_in[6] = 1'b0;
    tick(3);
    rd(1'b1, 8'hA0, v); chk("R6 fall", v, 32'h0000_0050);
    wr(1'b1, 8'hA0, 32'h0000_0010);
    rd(1'b1, 8'hA0, v); chk("R9 w1c", v, 32'h0000_0040);
    wr(1'b1, 8'hA0, 32'h0);
    rd(1'b1, 8'hA0, v); chk("R9 zero write", v, 32'h0000_0040);
    wr(1'b1, 8'h18, cfgw(4'hB, 1'b1));
    rd(1'b1, 8'hA0, v); chk("R10 cfg clear", v, 32'h0);
    rd(1'b1, 8'h18, v); chk("R10 code kept", v, 32'h000B_0000);
    chk("R11 irq off", {31'h0, irq}, 32'h0);
    wr(1'b1, 8'h0C, 32'h0); wr(1'b1, 8'h10, 32'h0); wr(1'b1, 8'h18, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(1'b1, 8'h1C, cfgw(4'hC, 1'b0));
    pin_in[7] = 1'b1;
    tick(3);
    rd(1'b1, 8'hA0, v); chk("R7 high level", v, 32'h0000_0080);
    clear_all();
    rd(1'b1, 8'hA0, v); chk("R9 clear wins", v, 32'h0);
    tick();
    rd(1'b1, 8'hA0, v); chk("R7 re-set", v, 32'h0000_0080);
    pin_in[7] = 1'b0;
    tick(3);
    clear_all();
    tick();
    rd(1'b1, 8'hA0, v); chk("R7 level gone", v, 32'h0);
    wr(1'b1, 8'h1C, 32'h0);
    wr(1'b1, 8'h20, cfgw(4'h8, 1'b0));
    tick();
    rd(1'b1, 8'hA0, v); chk("R7 low level", v, 32'h0000_0100);
    chk("R11 irq level", {31'h0, irq}, 32'h1);
    wr(1'b1, 8'h20, 32'h0);
    clear_all();
  endtask

  task automatic t_dma();
    logic [31:0] v;
    wr(1'b1, 8'h28, cfgw(4'h1, 1'b0));
    wr(1'b1, 8'h2C, cfgw(4'h2, 1'b0));
    wr(1'b1, 8'h30, cfgw(4'h3, 1'b0));
    pin_in[10] = 1'b1; pin_in[11] = 1'b1;
    tick(3);
    rd(1'b1, 8'hA0, v); chk("R8 dma rise", v, 32'h0000_0400);
    chk("R8 lines", {30'h0, irq, dma_req}, 32'h1);
    clear_all();
    chk("R8 dma off", {31'h0, dma_req}, 32'h0);
    pin_in[11] = 1'b0; pin_in[12] = 1'b1;
    tick(3);
    rd(1'b1, 8'hA0, v); chk("R8 fall/any", v, 32'h0000_1800);
    chk("R8 lines 2", {30'h0, irq, dma_req}, 32'h1);
    wr(1'b1, 8'h28, 32'h0); wr(1'b1, 8'h2C, 32'h0); wr(1'b1, 8'h30, 32'h0);
    pin_in[10] = 1'b0; pin_in[12] = 1'b0;
    tick(3);
    clear_all();
  endtask

  task automatic t_unknown();
    logic [31:0] v;
    wr(1'b1, 8'h34, cfgw(4'h5, 1'b0));
    wr(1'b1, 8'h38, cfgw(4'hF, 1'b0));
    wr(1'b1, 8'h40, cfgw(4'hD, 1'b0));
    pin_in[13] = 1'b1; pin_in[14] = 1'b1; pin_in[15] = 1'b1; pin_in[16] = 1'b1;
    tick(4);
    pin_in[13] = 1'b0; pin_in[14] = 1'b0; pin_in[15] = 1'b0; pin_in[16] = 1'b0;
    tick(4);
    rd(1'b1, 8'hA0, v); chk("R12 no flags", v, 32'h0);
    chk("R12 lines", {30'h0, irq, dma_req}, 32'h0);
    wr(1'b1, 8'h34, 32'h0); wr(1'b1, 8'h38, 32'h0); wr(1'b1, 8'h40, 32'h0);
  endtask

  task automatic t_combine();
    logic [31:0] v;
    wr(1'b1, 8'h50, cfgw(4'h9, 1'b0));
    wr(1'b1, 8'h54, cfgw(4'h1, 1'b0));
    pin_in[20] = 1'b1; pin_in[21] = 1'b1;
    tick(3);
    chk("R11 both", {30'h0, irq, dma_req}, 32'h3);
    wr(1'b1, 8'hA0, 32'h0010_0000);
    chk("R11 irq only cleared", {30'h0, irq, dma_req}, 32'h1);
    rd(1'b1, 8'hA0, v); chk("R9 partial", v, 32'h0020_0000);
    clear_all();
  endtask

  initial begin
    rst_n = 1'b0; pin_in = '0; reg_space = 1'b0; reg_addr = '0;
    reg_wr = 1'b0; reg_wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    t_reset();
    t_data();
    t_input();
    t_edge();
    t_level();
    t_dma();
    t_unknown();
    t_combine();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule